// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block derives the clock driven to a memory card from the controller's fixed input clock. The ratio is a power of two chosen by a small code, so the card clock can run anywhere from the full input rate down to one 128th of it. Software starts and stops the clock by writing one-shot request bits into a control word, and reads back a status word whose running flag tells it when a stop has actually completed.

Both stopping the clock and changing the ratio are deferred to the end of a divided period, where the card clock is low. No shortened pulse ever reaches the card. A start request may carry an operation-launch bit. The block turns that bit into a single-cycle pulse for the command engine, issued once the clock is running.

Top module: `card_clk_gen`

## Requirements
- R1: After reset the clock is stopped, `statusWord` is 0, `cardClk` is low, `opStart` is low and the applied ratio code is 0.
- R2: With an applied code N from 1 to 7, `cardClk` has a period of 2^N input cycles and a 50% duty. After a start it is first low for 2^(N-1) cycles. The slowest ratio (N=7) gives a period of 128.
- R3: With an applied code of 0 while running, `cardClk` follows the input clock: it is high while `clk` is high and low while `clk` is low.
- R4: A control write (`wrCtl` high) with `ctlWord` bit 1 set starts a stopped clock. `statusWord` bit 8 reads 1 from the edge that samples the write. All other status bits read 0.
- R5: A control write with bit 0 set stops a running clock only at the edge that ends a full divided period. At that edge `statusWord` bit 8 clears and `cardClk` is then held low. The clock keeps toggling normally until then.
- R6: When bits 0 and 1 are written in the same word, the stop wins. From the stopped state nothing starts and no `opStart` pulse is produced.
- R7: Bit 2 written together with bit 1, and without bit 0, produces exactly one `opStart` pulse of one cycle, while `statusWord` bit 8 is 1. Bit 2 written without bit 1 produces no pulse.
- R8: A code written via `wrDiv`/`divCode` is applied at the second edge after the write while the clock is stopped. While running, it is applied only at the end of a divided period, so the period in progress finishes at the old ratio.
- R9: A start write issued while a stop is still pending cancels the stop, and the clock keeps running.
- R10: A stop write while stopped has no effect. A start write while running leaves the clock phase undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrCtl | input | 1 | Control word write strobe |
| ctlWord | input | CTL_W | Control word: bit 0 stop, bit 1 start, bit 2 launch operation |
| wrDiv | input | 1 | Ratio code write strobe |
| divCode | input | CODE_W | Ratio code N, where the card clock is the input divided by 2^N |
| cardClk | output | 1 | Gated, divided card clock |
| statusWord | output | CTL_W | Status: bit 8 is 1 while the card clock runs |
| opStart | output | 1 | One-cycle operation launch pulse |

## Verification
The bench targets a stop that arrives mid-period; a design that gated at once would chop the high phase and clear status too early. It changes the ratio while running; a design that applied the change immediately would produce a distorted period. It also covers the combined stop-and-start word and a start issued while a stop is pending; errors there would leave the clock running when it should halt, or stopping when it should continue. Finally, it covers the undivided mode, where the clock is passed straight through; a wrongly timed gate there would leave the card clock stuck, or running after status reads stopped.

// File: rtl/card_clk_pkg.sv
`timescale 1ns/1ps
package card_clk_pkg;
  localparam int STOP_BIT     = 0;
  localparam int START_BIT    = 1;
  localparam int OP_BIT       = 2;
  localparam int RUN_STAT_BIT = 8;

  typedef struct packed {
    logic cntEn;    // divider counter advances
    logic codeLoad; // pending ratio code may be applied at this edge
  } clk_strb_t;
endpackage

// File: rtl/card_clk_ctrl.sv
`timescale 1ns/1ps
module card_clk_ctrl
  import card_clk_pkg::*;
#(
  parameter int CTL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCtl,
  input  logic [CTL_W-1:0] ctlWord,
  input  logic             wrap,
  output clk_strb_t        strb,
  output logic             running,
  output logic             opStart
);
  logic stopPend;
  logic stopHit, startHit, opHit, stopWant;

  always_comb begin
    stopHit  = wrCtl & ctlWord[STOP_BIT];
    startHit = wrCtl & ctlWord[START_BIT] & ~stopHit;
    opHit    = startHit & ctlWord[OP_BIT];
    stopWant = stopPend | (stopHit & running);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      stopPend <= 1'b0;
      opStart  <= 1'b0;
    end else begin
      opStart <= opHit;
      if (!running) begin
        stopPend <= 1'b0;
        if (startHit) running <= 1'b1;
      end else if (startHit) begin
        stopPend <= 1'b0;          // a start cancels any pending stop
      end else if (stopWant && wrap) begin
        running  <= 1'b0;          // close the gate at the period boundary
        stopPend <= 1'b0;
      end else if (stopWant) begin
        stopPend <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.cntEn    = running;
    strb.codeLoad = ~running | wrap;
  end

  // R7: a launch pulse only appears while the clock runs
  p_op_needs_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> running);

  // R6: stop wins over start in the same word
  p_stop_prio_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && ctlWord[STOP_BIT] && !running) |=> !running);

  // R5: the gate closes only at the end of a divided period
  p_stop_at_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(wrap));
endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/1ps
module card_clk_div
  import card_clk_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrDiv,
  input  logic [CODE_W-1:0] divCode,
  input  clk_strb_t         strb,
  output logic              wrap,
  output logic              cardClk
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] pendCode, codeQ;
  logic [CNT_W-1:0]  cnt, mask;
  logic [CNT_W:0]    maskW;
  logic              divBit, runLow;

  always_comb begin
    maskW = ({{CNT_W{1'b0}}, 1'b1} << codeQ) - 1'b1;
    mask  = maskW[CNT_W-1:0];
    wrap  = ((cnt & mask) == mask);
    if (codeQ == '0) divBit = 1'b0;
    else             divBit = cnt[codeQ - 1'b1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCode <= '0;
      codeQ    <= '0;
      cnt      <= '0;
    end else begin
      if (wrDiv)         pendCode <= divCode;
      if (strb.codeLoad) codeQ    <= pendCode;
      if (!strb.cntEn)   cnt      <= '0;
      else if (wrap)     cnt      <= '0;
      else               cnt      <= cnt + 1'b1;
    end
  end

  // enable for the undivided path changes only while clk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) runLow <= 1'b0;
    else       runLow <= strb.cntEn;
  end

  assign cardClk = (codeQ == '0) ? (clk & runLow) : divBit;

  // R2: every start begins at the start of a low phase
  p_start_from_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.cntEn) |-> (cnt == '0));

  // R8: the applied code holds inside a running period
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntEn && $past(strb.cntEn) && !$past(wrap)) |-> $stable(codeQ));
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CTL_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtl,
  input  logic [CTL_W-1:0]  ctlWord,
  input  logic              wrDiv,
  input  logic [CODE_W-1:0] divCode,
  output logic              cardClk,
  output logic [CTL_W-1:0]  statusWord,
  output logic              opStart
);
  clk_strb_t strb;
  logic      wrap, running;

  card_clk_ctrl #(.CTL_W(CTL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrCtl(wrCtl), .ctlWord(ctlWord),
    .wrap(wrap), .strb(strb), .running(running), .opStart(opStart)
  );

  card_clk_div #(.CODE_W(CODE_W)) div_i (
    .clk(clk), .rstN(rstN), .wrDiv(wrDiv), .divCode(divCode),
    .strb(strb), .wrap(wrap), .cardClk(cardClk)
  );

  always_comb begin
    statusWord = '0;
    statusWord[RUN_STAT_BIT] = running;
  end

  // R4: the status flag tracks the running state set by the controller
  p_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(statusWord) == int'(running));
endmodule

// File: tb/card_clk_gen_tb_top.sv
`timescale 1ns/1ps
module card_clk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrCtl = 1'b0;
  logic [15:0] ctlWord = '0;
  logic        wrDiv = 1'b0;
  logic [2:0]  divCode = '0;
  logic        cardClk;
  logic [15:0] statusWord;
  logic        opStart;

  int total = 0, bad = 0, opCount = 0, lowCount = 0;
  string curTag = "R1";

  // reference model state
  int mRun = 0, mStopPend = 0, mPend = 0, mCode = 0, mCnt = 0, mOp = 0, mRunPrev = 0;

  card_clk_gen dut_i (
    .clk(clk), .rstN(rstN), .wrCtl(wrCtl), .ctlWord(ctlWord),
    .wrDiv(wrDiv), .divCode(divCode), .cardClk(cardClk),
    .statusWord(statusWord), .opStart(opStart)
  );

  always #5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural model of the requirements
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mStopPend = 0; mPend = 0; mCode = 0; mCnt = 0; mOp = 0; mRunPrev = 0;
    end else begin
      int stopW, startW, opW, mask, wrp, want;
      stopW  = (wrCtl && ctlWord[0]) ? 1 : 0;
      startW = (wrCtl && ctlWord[1] && !stopW) ? 1 : 0;
      opW    = (startW && ctlWord[2]) ? 1 : 0;
      mask   = (1 << mCode) - 1;
      wrp    = ((mCnt & mask) == mask) ? 1 : 0;
      want   = (mStopPend || (stopW && mRun)) ? 1 : 0;
      mRunPrev = mRun;
      mOp = opW;
      if (!mRun || wrp) mCode = mPend;
      if (wrDiv) mPend = int'(divCode);
      if (!mRun) mCnt = 0; else if (wrp) mCnt = 0; else mCnt = mCnt + 1;
      if (!mRun) begin
        mStopPend = 0;
        if (startW) mRun = 1;
      end else if (startW) mStopPend = 0;
      else if (want && wrp) begin mRun = 0; mStopPend = 0; end
      else if (want) mStopPend = 1;
    end
  end

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      int expClk;
      expClk = (mCode == 0) ? mRunPrev : ((mCnt >> (mCode - 1)) & 1);
      chk(int'(cardClk), expClk, curTag, (mCode == 0) ? "cardClk R3" : "cardClk R2");
      chk(int'(statusWord), mRun << 8, curTag, "statusWord R4");
      chk(int'(opStart), mOp, curTag, "opStart R7");
      if (opStart) opCount++;
      if (!statusWord[8]) lowCount++;
    end
  end

  task automatic ctlWr(input logic [15:0] w);
    @(negedge clk); wrCtl = 1'b1; ctlWord = w;
    @(negedge clk); wrCtl = 1'b0; ctlWord = '0;
  endtask

  task automatic divWr(input logic [2:0] c);
    @(negedge clk); wrDiv = 1'b1; divCode = c;
    @(negedge clk); wrDiv = 1'b0; divCode = '0;
  endtask

  task automatic period(output int p);
    bit last = cardClk;
    int edges = 0, c = 0;
    while (edges < 2) begin
      @(posedge clk); #2;
      c++;
      if (cardClk && !last) begin
        edges++;
        if (edges == 1) c = 0;
      end
      last = cardClk;
    end
    p = c;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int p;
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk(int'(statusWord), 0, "R1", "reset status");
    chk(int'(cardClk), 0, "R1", "reset cardClk");
    chk(int'(opStart), 0, "R1", "reset opStart");
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R2: ratio 8
    curTag = "R2";
    divWr(3'd3);
    ctlWr(16'h0002);
    period(p);
    chk(p, 8, "R2", "period code 3");

    // R8: mid-period ratio change takes effect after the boundary
    curTag = "R8";
    repeat (3) @(posedge clk);
    divWr(3'd1);
    repeat (20) @(posedge clk);
    period(p);
    chk(p, 2, "R8", "period after change to code 1");

    // R10: start while running keeps phase (model compares each cycle)
    curTag = "R10";
    ctlWr(16'h0002);
    divWr(3'd3);
    repeat (20) @(posedge clk);

    // R5: stop at the period boundary
    curTag = "R5";
    ctlWr(16'h0001);
    repeat (20) @(posedge clk);
    #2;
    chk(int'(statusWord[8]), 0, "R5", "status after stop");
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #2;
      chk(int'(cardClk), 0, "R5", "cardClk held low");
    end

    // R10: stop while stopped
    curTag = "R10";
    ctlWr(16'h0001);
    repeat (3) @(posedge clk); #2;
    chk(int'(statusWord[8]), 0, "R10", "stop while stopped");

    // R6: stop and start together
    curTag = "R6";
    opCount = 0;
    ctlWr(16'h0007);
    repeat (5) @(posedge clk); #2;
    chk(int'(statusWord[8]), 0, "R6", "stop wins status");
    chk(opCount, 0, "R6", "stop wins no opStart");

    // R7: launch bit
    curTag = "R7";
    ctlWr(16'h0004);
    repeat (3) @(posedge clk); #2;
    chk(opCount, 0, "R7", "op bit alone");
    ctlWr(16'h0006);
    repeat (3) @(posedge clk); #2;
    chk(opCount, 1, "R7", "op with start");
    chk(int'(statusWord[8]), 1, "R4", "running after start");

    // R3: undivided clock
    curTag = "R3";
    divWr(3'd0);
    repeat (20) @(posedge clk);
    @(posedge clk); #2;
    chk(int'(cardClk), 1, "R3", "high phase");
    @(negedge clk); #2;
    chk(int'(cardClk), 0, "R3", "low phase");

    // R2 slowest ratio, then R9 cancel of a pending stop
    curTag = "R2";
    divWr(3'd7);
    period(p);
    chk(p, 128, "R2", "period code 7");
    curTag = "R9";
    lowCount = 0;
    ctlWr(16'h0001);
    ctlWr(16'h0002);
    repeat (300) @(posedge clk); #2;
    chk(lowCount, 0, "R9", "stop cancelled");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule